// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register bank of a system clock controller. It stores 32-bit words for nine PLL control registers, their bias and tuning words, bus divider settings, a memory-controller configuration word, a memory-bus reset word and two PLL settle-time words. Each word starts from a fixed value after reset. No clocks are generated here. Downstream logic, or software through the register bus, only sees the stored words.

Two behaviours stand in for the hardware the bank would normally sit beside. A PLL reports itself locked as soon as software enables it. The memory-controller "apply settings" flag clears itself, so software never reads it back as set. The register window is 0x308 bytes. Anything beyond it reads as zero and ignores writes.

Access uses a simple word bus with one byte address shared by reads and writes. A write is stored at the clock edge where `wr_en` is high. A read returns its data on `rd_data` after that edge.

Top module: `clkctl_csr`

## Requirements
- R1: The word index is the byte address shifted right by two. Address bits [1:0] are ignored for both reads and writes.
- R2: After reset, each word holds its fixed value. Examples: 0x000 = 0x00001000, 0x008 = 0x00035514, 0x010 = 0x03006207, 0x028 = 0x00041811, 0x0FC = 0x80000000, 0x200 and 0x204 = 0x000000FF, 0x220 = 0x08100200, 0x260 = 0x14880000, 0x0F4 = 0. Byte offsets below 0x308 with no defined register reset to 0.
- R3: A write to a PLL control word (byte offsets 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x038, 0x044, 0x048) with bit 31 (enable) set stores bit 28 (lock) as 1. With bit 31 clear, the word is stored as written.
- R4: A write to the memory-controller configuration word at 0x0F4 always stores bit 16 as 0. All other bits are stored as written.
- R5: A read at byte offset 0x308 or above returns 0.
- R6: A write at byte offset 0x308 or above changes no stored word.
- R7: Every other word below 0x308 stores the written value unchanged, including bit 31 and bit 28 of non-PLL words.
- R8: Read data appears on `rd_data` in the cycle after `rd_en` and holds while `rd_en` is low. A read and a write to the same address in the same cycle return the value stored before the write.
- R9: Holding `rst_n` low at a clock edge restores every word to its R2 value, whatever was written before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (12) | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is a write outside the window that lands on a real word through address truncation. Such a write looks harmless unless a defined word that would alias it is read back afterwards. The stimulus writes all-ones at 0x308 and 0x400. 0x400 shares its low index bits with word 0. It then reads word 0 and the last in-window word to confirm both kept their values. A second subtle case is a read and a write on the same address in the same cycle. The stimulus drives both strobes together and expects the old value, then reads again to see the new one.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int WORD_W       = 32;
    localparam int PLL_EN_BIT   = 31;
    localparam int PLL_LOCK_BIT = 28;
    localparam int MEM_UPD_BIT  = 16;
    localparam int unsigned MEM_CFG_OFF = 32'h0F4;

    // Byte offsets of the nine PLL control words.
    function automatic logic is_pll_ctl(input int unsigned off);
        return off inside {32'h000, 32'h008, 32'h010, 32'h018, 32'h020,
                           32'h028, 32'h038, 32'h044, 32'h048};
    endfunction

    // Value loaded at reset for the word at a given byte offset.
    function automatic logic [WORD_W-1:0] reset_word(input int unsigned off);
        logic [WORD_W-1:0] v;
        case (off)
            32'h010, 32'h018, 32'h038, 32'h048:  v = 32'h0300_6207;
            32'h000, 32'h020:                    v = 32'h0000_1000;
            32'h028, 32'h044:                    v = 32'h0004_1811;
            32'h008:                             v = 32'h0003_5514;
            32'h200, 32'h204:                    v = 32'h0000_00FF;
            32'h050:                             v = 32'h0001_0000;
            32'h054:                             v = 32'h0000_1010;
            32'h058:                             v = 32'h0100_0000;
            32'h0FC:                             v = 32'h8000_0000;
            32'h224, 32'h228, 32'h22C, 32'h23C,
            32'h248:                             v = 32'h1010_0000;
            32'h234, 32'h244:                    v = 32'h1010_0010;
            32'h220:                             v = 32'h0810_0200;
            32'h230:                             v = 32'h8110_4000;
            32'h250:                             v = 32'h0A10_1000;
            32'h260:                             v = 32'h1488_0000;
            default:                             v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/clkctl_addr_dec.sv
module clkctl_addr_dec
    import clkctl_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WINDOW_BYTES = 32'h308,
    parameter int IDX_W        = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_win,
    output logic              is_pll,
    output logic              is_mem
);
    localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(WINDOW_BYTES);

    logic [31:0] off_w;

    always_comb begin
        off_w  = 32'({addr[ADDR_W-1:2], 2'b00});
        idx    = addr[IDX_W+1:2];
        in_win = (addr < WIN_LIM);
        is_pll = in_win && is_pll_ctl(off_w);
        is_mem = in_win && (off_w == MEM_CFG_OFF);
    end
endmodule

// File: rtl/clkctl_wr_shape.sv
module clkctl_wr_shape
    import clkctl_pkg::*;
(
    input  logic              is_pll,
    input  logic              is_mem,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] shaped
);
    always_comb begin
        shaped = wdata;
        if (is_pll && wdata[PLL_EN_BIT]) begin
            shaped[PLL_LOCK_BIT] = 1'b1;
        end
        if (is_mem) begin
            shaped[MEM_UPD_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/clkctl_csr.sv
module clkctl_csr
    import clkctl_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WINDOW_BYTES = 32'h308
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data
);
    localparam int NUM_WORDS = WINDOW_BYTES / 4;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int MEM_IDX   = MEM_CFG_OFF / 4;

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] bank_t;

    typedef struct packed {
        bank_t             regs;
        logic [WORD_W-1:0] rd;
    } state_t;

    function automatic bank_t build_bank();
        bank_t b;
        for (int i = 0; i < NUM_WORDS; i++) begin
            b[i] = reset_word(32'(i * 4));
        end
        return b;
    endfunction

    localparam bank_t RST_BANK = build_bank();

    state_t            s_d, s_q;
    logic [IDX_W-1:0]  w_idx;
    logic              w_in, w_pll, w_mem;
    logic [WORD_W-1:0] w_shaped;

    clkctl_addr_dec #(
        .ADDR_W      (ADDR_W),
        .WINDOW_BYTES(WINDOW_BYTES),
        .IDX_W       (IDX_W)
    ) u_dec (
        .addr  (addr),
        .idx   (w_idx),
        .in_win(w_in),
        .is_pll(w_pll),
        .is_mem(w_mem)
    );

    clkctl_wr_shape u_shape (
        .is_pll(w_pll),
        .is_mem(w_mem),
        .wdata (wr_data),
        .shaped(w_shaped)
    );

    always_comb begin
        s_d = s_q;
        if (rd_en) begin
            s_d.rd = w_in ? s_q.regs[w_idx] : '0;
        end
        if (wr_en && w_in) begin
            s_d.regs[w_idx] = w_shaped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.regs <= RST_BANK;
            s_q.rd   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rd;

    // R3: enabling a PLL reports lock in the stored word
    a_r3_pll_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_pll && wr_data[PLL_EN_BIT])
        |=> s_q.regs[$past(w_idx)][PLL_LOCK_BIT]);

    // R4: update flag never remains stored
    a_r4_mem_upd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_mem) |=> !s_q.regs[MEM_IDX][MEM_UPD_BIT]);

    // R5: reads outside the window are zero
    a_r5_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !w_in) |=> (rd_data == '0));

    // R6: writes outside the window leave the bank untouched
    a_r6_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !w_in) |=> $stable(s_q.regs));

    // R7: ordinary words keep the written value
    a_r7_plain_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_in && !w_pll && !w_mem)
        |=> (s_q.regs[$past(w_idx)] == $past(wr_data)));

    // R8: read data holds without a read strobe
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_clkctl_csr.sv
module tb_clkctl_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;  // 50 MHz

    clkctl_csr dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset_values();
        expect_rd("R2 cpu pll", 12'h000, 32'h0000_1000);
        expect_rd("R2 audio pll", 12'h008, 32'h0003_5514);
        expect_rd("R2 video pll", 12'h010, 32'h0300_6207);
        expect_rd("R2 periph pll", 12'h028, 32'h0004_1811);
        expect_rd("R2 mbus", 12'h0FC, 32'h8000_0000);
        expect_rd("R2 settle0", 12'h200, 32'h0000_00FF);
        expect_rd("R2 settle1", 12'h204, 32'h0000_00FF);
        expect_rd("R2 cpu bias", 12'h220, 32'h0810_0200);
        expect_rd("R2 ddr tuning", 12'h260, 32'h1488_0000);
        expect_rd("R2 mem cfg", 12'h0F4, 32'h0000_0000);
        expect_rd("R2 undefined", 12'h100, 32'h0000_0000);
    endtask

    task automatic t_pll_lock();
        wr(12'h000, 32'h8000_1234);
        expect_rd("R3 lock forced 0x000", 12'h000, 32'h9000_1234);
        wr(12'h044, 32'h80FF_0000);
        expect_rd("R3 lock forced 0x044", 12'h044, 32'h90FF_0000);
        wr(12'h010, 32'h0000_1234);
        expect_rd("R3 disabled as written", 12'h010, 32'h0000_1234);
        wr(12'h018, 32'h1000_0055);
        expect_rd("R3 lock kept w/o enable", 12'h018, 32'h1000_0055);
    endtask

    task automatic t_mem_cfg();
        wr(12'h0F4, 32'hFFFF_FFFF);
        expect_rd("R4 update cleared", 12'h0F4, 32'hFFFE_FFFF);
        wr(12'h0F4, 32'h0001_0001);
        expect_rd("R4 only update bit", 12'h0F4, 32'h0000_0001);
    endtask

    task automatic t_plain();
        wr(12'h0FC, 32'h1234_ABCD);
        expect_rd("R7 mbus", 12'h0FC, 32'h1234_ABCD);
        wr(12'h050, 32'h8000_0001);
        expect_rd("R7 no lock on non-pll", 12'h050, 32'h8000_0001);
        wr(12'h100, 32'hDEAD_BEEF);
        expect_rd("R7 undefined storage", 12'h100, 32'hDEAD_BEEF);
        wr(12'h304, 32'hA5A5_A5A5);
        expect_rd("R7 last word", 12'h304, 32'hA5A5_A5A5);
    endtask

    task automatic t_out_of_window();
        wr(12'h308, 32'hFFFF_FFFF);
        wr(12'h400, 32'hFFFF_FFFF);
        expect_rd("R5 read 0x308", 12'h308, 32'h0);
        expect_rd("R5 read 0xFFC", 12'hFFC, 32'h0);
        expect_rd("R6 word 0 untouched", 12'h000, 32'h9000_1234);
        expect_rd("R6 last word untouched", 12'h304, 32'hA5A5_A5A5);
    endtask

    task automatic t_addr_lsb();
        wr(12'h102, 32'h1111_2222);
        expect_rd("R1 aligned read", 12'h100, 32'h1111_2222);
        expect_rd("R1 low bits ignored", 12'h103, 32'h1111_2222);
    endtask

    task automatic t_read_timing();
        logic [31:0] v;
        rd(12'h0FC, v);
        check("R8 one-cycle read", v, 32'h1234_ABCD);
        @(negedge clk);
        addr = 12'h000;
        @(negedge clk);
        @(negedge clk);
        check("R8 hold without strobe", rd_data, 32'h1234_ABCD);
        @(negedge clk);
        addr = 12'h104; wr_data = 32'h5555_AAAA; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8 same-cycle read old", rd_data, 32'h0);
        expect_rd("R8 then new value", 12'h104, 32'h5555_AAAA);
    endtask

    task automatic t_reset_restore();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        expect_rd("R9 pll restored", 12'h000, 32'h0000_1000);
        expect_rd("R9 mbus restored", 12'h0FC, 32'h8000_0000);
        expect_rd("R9 undefined cleared", 12'h100, 32'h0);
        expect_rd("R9 mem cfg cleared", 12'h0F4, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R2 rd_data after reset", rd_data, 32'h0);
        t_reset_values();
        t_pll_lock();
        t_mem_cfg();
        t_plain();
        t_out_of_window();
        t_addr_lsb();
        t_read_timing();
        t_reset_restore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got=timeout exp=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule